// File: doc/BRIEF.md
# Segmented LRU Victim Selector

This block holds the replacement state of one 16-way cache set and names the way to replace on the next fill. Every way carries a 4-bit recency position, where 0 is most recent and 15 is least recent. Every way also has a reference bit. A set bit marks the line as protected, and a clear bit leaves it exposed to eviction. Lines that are exposed are evicted first, oldest first. Only when every valid line is protected does the plain least-recent line go. Invalid ways are always filled before any valid way is displaced.

Hits set the reference bit of the hit way and move it to the most recent position. A fill writes the chosen victim way and also ages the set: the line sitting at the least-recent position loses its reference bit. A freshly filled line starts protected only when a 5-bit random input is all zeros at fill time. With uniform random bits that happens once in 32 fills.

Tag compare and data storage are outside this block. One instance serves one set, and the surrounding logic replicates it or indexes it. The hit and fill strobes are plain control pins with no back-pressure: an update is accepted on every clock edge where a strobe is high.

Top module: `slru_victim_sel`

## Requirements
- R1: While reset is asserted, way i holds recency position i. All reference bits and all valid bits are 0, and `victim_way` is 0.
- R2: While any way is invalid, `victim_way` is the lowest-numbered invalid way.
- R3: When all ways are valid and at least one reference bit is clear, `victim_way` is the unreferenced way with the largest recency position.
- R4: When all ways are valid and all reference bits are set, `victim_way` is the way whose position is 15.
- R5: A hit on way h updates the state as follows on the next edge:
  - the reference bit of h becomes 1 and h moves to position 0;
  - every way whose position was below h's old position goes up by one;
  - all other positions and all valid bits stay unchanged.
- R6: A fill (fill strobe high, hit strobe low) updates the state as follows on the next edge:
  - the way shown on `victim_way` becomes valid and moves to position 0;
  - every way with a smaller old position goes up by one.
- R7: On a fill, the filled way's reference bit becomes 1 if `rnd_bits` is all zeros in that cycle. Otherwise it becomes 0.
- R8: On a fill, the way at position 15 before the fill has its reference bit cleared, unless that way is the filled way, in which case R7 applies.
- R9: When the hit and fill strobes are both high, the fill has no effect. Only the hit update of R5 takes place, and no valid bit changes.
- R10: The sixteen recency positions are always a permutation of 0 to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | Hit strobe for this set |
| hit_way | input | 4 | Way that hit |
| alloc_valid | input | 1 | Fill strobe; the fill goes into `victim_way` |
| rnd_bits | input | 5 | Random bits; all zeros promotes the filled line |
| victim_way | output | 4 | Way chosen for the next fill (combinational from state) |
| pos_flat | output | 64 | Recency position of way i in bits [4i+3:4i] |
| ref_bits | output | 16 | Reference bit per way |
| valid_bits | output | 16 | Valid bit per way |

## Verification
`victim_way` is a pure function of the registered state, so it is due in the same cycle as the state it reflects. The bench samples it at the falling edge before it drives a strobe. Position, reference and valid updates appear one edge after the strobe. The bench therefore samples them a short delay after that rising edge and compares them against a model that was advanced by exactly one step. The aging, promotion and hit-over-fill cases are set up so that the affected bit is read at the ports in the cycle right after the fill.

// File: rtl/slru_pkg.sv
package slru_pkg;
  parameter int unsigned SLRU_WAYS_DEF  = 16;
  parameter int unsigned SLRU_PROMO_DEF = 5;
endpackage

// File: rtl/slru_victim_pick.sv
module slru_victim_pick #(
  parameter int unsigned WAYS = 16,
  localparam int unsigned POS_W = $clog2(WAYS)
) (
  input  logic [WAYS*POS_W-1:0] pos_flat,
  input  logic [WAYS-1:0]       ref_bits,
  input  logic [WAYS-1:0]       valid_bits,
  output logic [POS_W-1:0]      victim
);
  localparam logic [POS_W-1:0] LAST = POS_W'(WAYS-1);

  logic             inv_found, unref_found;
  logic [POS_W-1:0] inv_way, unref_way, unref_pos, lru_way;

  always_comb begin
    inv_found   = 1'b0;
    unref_found = 1'b0;
    inv_way     = '0;
    unref_way   = '0;
    unref_pos   = '0;
    lru_way     = '0;
    for (int i = 0; i < int'(WAYS); i++) begin
      if (!valid_bits[i] && !inv_found) begin
        inv_found = 1'b1;
        inv_way   = POS_W'(i);
      end
      if (!ref_bits[i] &&
          (!unref_found || pos_flat[i*POS_W +: POS_W] > unref_pos)) begin
        unref_found = 1'b1;
        unref_way   = POS_W'(i);
        unref_pos   = pos_flat[i*POS_W +: POS_W];
      end
      if (pos_flat[i*POS_W +: POS_W] == LAST) lru_way = POS_W'(i);
    end
    if (inv_found)        victim = inv_way;
    else if (unref_found) victim = unref_way;
    else                  victim = lru_way;
  end
endmodule

// File: rtl/slru_state.sv
module slru_state #(
  parameter int unsigned WAYS = 16,
  localparam int unsigned POS_W = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hit_valid,
  input  logic [POS_W-1:0]      hit_way,
  input  logic                  alloc_valid,
  input  logic                  promote,
  input  logic [POS_W-1:0]      victim,
  output logic [WAYS*POS_W-1:0] pos_flat,
  output logic [WAYS-1:0]       ref_q,
  output logic [WAYS-1:0]       valid_q
);
  localparam logic [POS_W-1:0] LAST = POS_W'(WAYS-1);

  logic [POS_W-1:0] pos_q [WAYS];
  logic [POS_W-1:0] pos_n [WAYS];
  logic [WAYS-1:0]  ref_n, valid_n;
  logic [POS_W-1:0] acc_way, acc_pos;
  logic             upd;

  always_comb begin
    acc_way = hit_valid ? hit_way : victim;
    acc_pos = pos_q[acc_way];
    upd     = hit_valid | alloc_valid;
    pos_n   = pos_q;
    ref_n   = ref_q;
    valid_n = valid_q;
    if (upd) begin
      for (int i = 0; i < int'(WAYS); i++) begin
        if (acc_way == POS_W'(i))       pos_n[i] = '0;
        else if (pos_q[i] < acc_pos)    pos_n[i] = pos_q[i] + 1'b1;
      end
    end
    if (hit_valid) begin
      ref_n[hit_way] = 1'b1;
    end else if (alloc_valid) begin
      for (int i = 0; i < int'(WAYS); i++) begin
        if (pos_q[i] == LAST) ref_n[i] = 1'b0;
      end
      ref_n[victim]   = promote;
      valid_n[victim] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(WAYS); i++) pos_q[i] <= POS_W'(i);
      ref_q   <= '0;
      valid_q <= '0;
    end else begin
      pos_q   <= pos_n;
      ref_q   <= ref_n;
      valid_q <= valid_n;
    end
  end

  for (genvar g = 0; g < int'(WAYS); g++) begin : g_flat
    assign pos_flat[g*POS_W +: POS_W] = pos_q[g];
  end

  logic [WAYS-1:0] occ;
  always_comb begin
    occ = '0;
    for (int i = 0; i < int'(WAYS); i++) occ[pos_q[i]] = 1'b1;
  end

  a_r10_perm: assert property (@(posedge clk) disable iff (!rst_n) &occ);
  a_r5_hit_mru: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |=> pos_q[$past(hit_way)] == '0);
  a_r5_hit_ref: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |=> ref_q[$past(hit_way)]);
  a_r6_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !hit_valid) |=> valid_q[$past(victim)] && pos_q[$past(victim)] == '0);
  a_r7_promo: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !hit_valid) |=> ref_q[$past(victim)] == $past(promote));
  a_r9_hit_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && hit_valid) |=> valid_q == $past(valid_q));
endmodule

// File: rtl/slru_victim_sel.sv
module slru_victim_sel
  import slru_pkg::*;
#(
  parameter int unsigned WAYS       = SLRU_WAYS_DEF,
  parameter int unsigned PROMO_BITS = SLRU_PROMO_DEF,
  localparam int unsigned POS_W     = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hit_valid,
  input  logic [POS_W-1:0]      hit_way,
  input  logic                  alloc_valid,
  input  logic [PROMO_BITS-1:0] rnd_bits,
  output logic [POS_W-1:0]      victim_way,
  output logic [WAYS*POS_W-1:0] pos_flat,
  output logic [WAYS-1:0]       ref_bits,
  output logic [WAYS-1:0]       valid_bits
);
  localparam logic [POS_W-1:0] LAST = POS_W'(WAYS-1);

  logic promote;
  assign promote = ~|rnd_bits;

  slru_victim_pick #(.WAYS(WAYS)) u_pick (
    .pos_flat   (pos_flat),
    .ref_bits   (ref_bits),
    .valid_bits (valid_bits),
    .victim     (victim_way)
  );

  slru_state #(.WAYS(WAYS)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit_valid   (hit_valid),
    .hit_way     (hit_way),
    .alloc_valid (alloc_valid),
    .promote     (promote),
    .victim      (victim_way),
    .pos_flat    (pos_flat),
    .ref_q       (ref_bits),
    .valid_q     (valid_bits)
  );

  a_r2_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
    !(&valid_bits) |-> !valid_bits[victim_way]);
  a_r3_unref_first: assert property (@(posedge clk) disable iff (!rst_n)
    ((&valid_bits) && !(&ref_bits)) |-> !ref_bits[victim_way]);
  a_r4_global_lru: assert property (@(posedge clk) disable iff (!rst_n)
    ((&valid_bits) && (&ref_bits)) |-> pos_flat[victim_way*POS_W +: POS_W] == LAST);
endmodule

// File: tb/slru_victim_sel_bench.sv
module slru_victim_sel_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hit_valid, alloc_valid;
  logic [3:0]  hit_way;
  logic [4:0]  rnd_bits;
  logic [3:0]  victim_way;
  logic [63:0] pos_flat;
  logic [15:0] ref_bits, valid_bits;

  int errs = 0;
  int checks = 0;

  int          mpos [16];
  logic [15:0] mref, mval;

  always #5 clk = ~clk;

  slru_victim_sel u_slru_victim_sel (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_way(hit_way),
    .alloc_valid(alloc_valid), .rnd_bits(rnd_bits), .victim_way(victim_way),
    .pos_flat(pos_flat), .ref_bits(ref_bits), .valid_bits(valid_bits)
  );

  // {op nibble (bit0 hit, bit1 fill), way nibble, rnd byte}
  localparam int NV = 26;
  localparam logic [15:0] TBL [NV] = '{
    16'h2001, 16'h2001, 16'h2001, 16'h2000, 16'h2001, 16'h2001, 16'h2001,
    16'h2001, 16'h2001, 16'h2000, 16'h2001, 16'h2001, 16'h2001, 16'h2001,
    16'h2001, 16'h2001, 16'h1501, 16'h1201, 16'h2001, 16'h3701, 16'h2001,
    16'h2000, 16'h1001, 16'h0001, 16'h2001, 16'h1F01
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < 16; i++) mpos[i] = i;
    mref = '0;
    mval = '0;
  endfunction

  function automatic int model_victim();
    int best = -1;
    for (int i = 0; i < 16; i++) if (!mval[i]) return i;
    for (int i = 0; i < 16; i++)
      if (!mref[i] && (best < 0 || mpos[i] > mpos[best])) best = i;
    if (best >= 0) return best;
    for (int i = 0; i < 16; i++) if (mpos[i] == 15) return i;
    return 0;
  endfunction

  function automatic string victim_tag();
    if (mval != 16'hFFFF) return "R2 victim";
    if (mref != 16'hFFFF) return "R3 victim";
    return "R4 victim";
  endfunction

  function automatic logic [63:0] model_pos();
    logic [63:0] r;
    for (int i = 0; i < 16; i++) r[i*4 +: 4] = 4'(mpos[i]);
    return r;
  endfunction

  function automatic void model_step(input int op, input int way, input logic [4:0] rnd, input int v);
    int acc;
    int p;
    if (op[0]) acc = way;
    else if (op[1]) acc = v;
    else return;
    if (op[0]) mref[way] = 1'b1;
    else begin
      for (int i = 0; i < 16; i++) if (mpos[i] == 15) mref[i] = 1'b0;
      mref[v] = (rnd == 5'd0);
      mval[v] = 1'b1;
    end
    p = mpos[acc];
    for (int i = 0; i < 16; i++) begin
      if (i == acc) mpos[i] = 0;
      else if (mpos[i] < p) mpos[i] = mpos[i] + 1;
    end
  endfunction

  task automatic do_op(input int op, input int way, input logic [4:0] rnd);
    int ev;
    @(negedge clk);
    ev = model_victim();
    chk(victim_tag(), 64'(victim_way), 64'(ev));
    hit_valid   = op[0];
    alloc_valid = op[1];
    hit_way     = 4'(way);
    rnd_bits    = rnd;
    @(posedge clk);
    #1;
    hit_valid   = 1'b0;
    alloc_valid = 1'b0;
    model_step(op, way, rnd, ev);
    chk(op[0] ? "R5/R10 positions" : "R6/R10 positions", pos_flat, model_pos());
    chk(op[0] ? "R5 ref" : "R7/R8 ref", 64'(ref_bits), 64'(mref));
    chk(op == 3 ? "R9 valid" : "R6 valid", 64'(valid_bits), 64'(mval));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [15:0] e;
    int y;
    rst_n = 1'b0;
    hit_valid = 1'b0;
    alloc_valid = 1'b0;
    hit_way = '0;
    rnd_bits = 5'd1;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 victim", 64'(victim_way), 64'd0);
    chk("R1 positions", pos_flat, model_pos());
    chk("R1 ref", 64'(ref_bits), 64'd0);
    chk("R1 valid", 64'(valid_bits), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      e = TBL[k];
      do_op(int'(e[15:12]), int'(e[11:8]), e[4:0]);
    end

    // R4: every line referenced
    for (int w = 0; w < 16; w++) do_op(1, w, 5'd1);
    do_op(2, 0, 5'd1);
    // R8: the LRU line is referenced and is not the victim
    y = 0;
    for (int i = 0; i < 16; i++) if (mpos[i] == 15) y = i;
    do_op(2, 0, 5'd1);
    chk("R8 aged LRU ref", 64'(ref_bits[y]), 64'd0);

    // R7: promoted fill directly
    do_op(2, 0, 5'd0);

    // R2: invalid ways after a fresh reset
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    do_op(2, 0, 5'd1);
    do_op(2, 0, 5'd1);
    do_op(2, 0, 5'd1);
    @(negedge clk);
    chk("R2 lowest invalid", 64'(victim_way), 64'd3);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule